// File: doc/BRIEF.md
# Protection Fault Manager with Auto-Recovery

This block sits between the protection comparators of a switching power controller and its PWM stage. It watches six fault sources: die over-temperature shutdown, an external over-temperature comparator, an external over-voltage comparator, the supply over-voltage comparator, the overload-timer flag and the short-circuit flag. From these it decides when switching must stop and when it may start again. The three external and supply comparators are raw levels. Each passes through a glitch filter counted in prescaled ticks, and any drop during the window restarts that count. The overload and short-circuit flags are accepted only while switching is enabled.

When any fault is taken, the switching enable drops and the fault-mode indicator rises on the next clock edge. A recovery timer then starts. Each kind of fault has its own exit rule. Overload and short-circuit faults clear when the timer expires. The external over-voltage fault clears at expiry only if its input has gone low; otherwise the timer re-arms. The external over-temperature fault also needs a recovered-temperature flag. Either external fault can be set to latch through an option bit. Supply over-voltage always latches. Die shutdown follows its input directly. The only way out of a latched fault is a supply undervoltage or an input-line reset level, and either one also clears all fault state.

All pins are plain control and status levels. There is no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `prot_fault_mgr`

## Requirements
- R1: While `rst_n` is low, and after it is released with no fault input active, `sw_en_o`=1, `fault_mode_o`=0 and `det_clr_o`=0.
- R2: A fault from `otp_i`, `ovp_i` or `sovp_i` is taken only after the input has been high on OTP_TICKS, OVP_TICKS or SOVP_TICKS consecutive ticks (one tick every TICK_DIV clocks). A single low cycle restarts the count.
- R3: `otp_i` has no effect while `ss_done_i`=0.
- R4: `tsd_i`=1 gives `fault_mode_o`=1 and `sw_en_o`=0 one clock later. That fault clears one clock after `tsd_i` returns to 0, provided no other fault is pending.
- R5: On any fault entry, `sw_en_o` falls and `fault_mode_o` rises on the same clock edge, one edge after the qualifying input.
- R6: `ovld_i` and `scp_i` are taken only while `sw_en_o`=1. Such a fault clears AR_TICKS ticks after entry, give or take one tick.
- R7: An auto-recovering over-temperature fault clears only when the timer has expired and `otp_rec_i`=1. If the flag is low at expiry, the block waits for the flag.
- R8: If `ovp_i` is still high when the timer expires, the fault remains and the timer restarts. After `ovp_i` falls, the fault clears within one timer period.
- R9: With `otp_latch_i`=1 or `ovp_latch_i`=1, the matching fault never clears on its own.
- R10: A supply over-voltage fault never clears on its own.
- R11: While `vcc_uv_i` or `uvlo_rst_i` is high, all faults and filters are cleared, with `sw_en_o`=0 and `fault_mode_o`=0. After release, switching resumes with no `det_clr_o` pulse.
- R12: When the block leaves fault mode, `det_clr_o` is high for exactly one cycle, in the same cycle that `sw_en_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tsd_i | input | 1 | Die over-temperature shutdown level |
| otp_i | input | 1 | External over-temperature comparator level |
| otp_rec_i | input | 1 | Temperature back above recovery level |
| ovp_i | input | 1 | External over-voltage comparator level |
| sovp_i | input | 1 | Supply over-voltage comparator level |
| ovld_i | input | 1 | Overload timer expired flag |
| scp_i | input | 1 | Short-circuit count reached flag |
| ss_done_i | input | 1 | Soft-start finished |
| otp_latch_i | input | 1 | 1: over-temperature fault latches |
| ovp_latch_i | input | 1 | 1: external over-voltage fault latches |
| vcc_uv_i | input | 1 | Supply below minimum (reset condition) |
| uvlo_rst_i | input | 1 | Line sense below reset level (reset condition) |
| sw_en_o | output | 1 | Switching enabled |
| fault_mode_o | output | 1 | Low-power fault mode |
| det_clr_o | output | 1 | One-cycle clear to overload/short-circuit detectors |

## Verification
The assertions check the rules that hold on every cycle. Die shutdown blocks switching on the next edge. A reset condition silences both outputs. Supply over-voltage, once set, stays set. An over-temperature fault never appears before soft-start has ended. Overload is taken only while switching is enabled. The recovery-done state stays held, and the detector clear is a single pulse that comes with the enable. Only the bench scenarios can show the timing and recovery behaviour: filter windows being restarted by glitches, recovery periods measured against the tick count, the re-arm caused by a held over-voltage input, the wait for the recovered-temperature flag, and the latch options that hold indefinitely.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int unsigned NUM_CAUSE = 5;
  localparam int unsigned NUM_FILT  = 3;
  // cause indices; the first NUM_FILT are the filtered comparator causes
  localparam int unsigned CI_OTP  = 0;
  localparam int unsigned CI_OVP  = 1;
  localparam int unsigned CI_SOVP = 2;
  localparam int unsigned CI_OVLD = 3;
  localparam int unsigned CI_SCP  = 4;
  typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/pfm_tick_gen.sv
module pfm_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pfm_level_filter.sv
module pfm_level_filter #(
  parameter int unsigned N_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic level_i,
  output logic fire_o
);
  localparam int unsigned W = $clog2(N_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(N_TICKS - 1);
  localparam logic [W-1:0] FULL = W'(N_TICKS);

  logic [W-1:0] cnt_q;

  // fires once, on the N-th consecutive tick seen with the level high
  assign fire_o = level_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr_i || !level_i)         cnt_q <= '0;
    else if (tick_i && (cnt_q != FULL)) cnt_q <= cnt_q + 1'b1;
  end

  AST_FILT_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R2
endmodule

// File: rtl/pfm_ar_timer.sv
module pfm_ar_timer #(
  parameter int unsigned N_TICKS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(N_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(N_TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!active_i || restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  AST_AR_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && active_i && !restart_i |=> done_o); // R6
endmodule

// File: rtl/prot_fault_mgr.sv
module prot_fault_mgr
  import pfm_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 100,
  parameter int unsigned OTP_TICKS  = 20000,
  parameter int unsigned OVP_TICKS  = 5000,
  parameter int unsigned SOVP_TICKS = 3000,
  parameter int unsigned AR_TICKS   = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tsd_i,
  input  logic otp_i,
  input  logic otp_rec_i,
  input  logic ovp_i,
  input  logic sovp_i,
  input  logic ovld_i,
  input  logic scp_i,
  input  logic ss_done_i,
  input  logic otp_latch_i,
  input  logic ovp_latch_i,
  input  logic vcc_uv_i,
  input  logic uvlo_rst_i,
  output logic sw_en_o,
  output logic fault_mode_o,
  output logic det_clr_o
);
  localparam int unsigned FILT_TICKS [NUM_FILT] = '{OTP_TICKS, OVP_TICKS, SOVP_TICKS};

  logic                hard_in, hard_q;
  logic                tick;
  logic [NUM_FILT-1:0] filt_lvl, filt_fire;
  cause_vec_t          cause_q, cause_d, set_mask, clr_mask;
  logic                tsd_q, tsd_d;
  logic                fault_now, fault_d;
  logic                dyn_accept, ovp_rearm, restart, ar_done;
  logic                det_clr_q;

  assign hard_in = vcc_uv_i | uvlo_rst_i;

  pfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  // over-temperature detection is held off until soft-start has finished
  assign filt_lvl[CI_OTP]  = otp_i & ss_done_i;
  assign filt_lvl[CI_OVP]  = ovp_i;
  assign filt_lvl[CI_SOVP] = sovp_i;

  for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_filt
    pfm_level_filter #(.N_TICKS(FILT_TICKS[gi])) u_filt (
      .clk(clk), .rst_n(rst_n), .clr_i(hard_in), .tick_i(tick),
      .level_i(filt_lvl[gi]), .fire_o(filt_fire[gi])
    );
  end

  // detector flags only count while switching, and not in the clear cycle
  assign dyn_accept = sw_en_o && !det_clr_o;

  always_comb begin
    set_mask                = '0;
    set_mask[NUM_FILT-1:0]  = filt_fire;
    set_mask[CI_OVLD]       = ovld_i & dyn_accept;
    set_mask[CI_SCP]        = scp_i & dyn_accept;
  end

  always_comb begin
    clr_mask = '0;
    if (ar_done) begin
      clr_mask[CI_OVLD] = 1'b1;
      clr_mask[CI_SCP]  = 1'b1;
      clr_mask[CI_OVP]  = !ovp_latch_i && !ovp_i;
      clr_mask[CI_OTP]  = !otp_latch_i && otp_rec_i;
    end
  end

  assign ovp_rearm = ar_done && cause_q[CI_OVP] && !ovp_latch_i && ovp_i;
  assign restart   = (|(set_mask & ~cause_q)) || ovp_rearm;

  pfm_ar_timer #(.N_TICKS(AR_TICKS)) u_ar (
    .clk(clk), .rst_n(rst_n), .active_i(|cause_q), .restart_i(restart),
    .tick_i(tick), .done_o(ar_done)
  );

  assign cause_d   = hard_in ? '0 : ((cause_q & ~clr_mask) | set_mask);
  assign tsd_d     = !hard_in && tsd_i;
  assign fault_now = (|cause_q) || tsd_q;
  assign fault_d   = (|cause_d) || tsd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q   <= '0;
      tsd_q     <= 1'b0;
      hard_q    <= 1'b0;
      det_clr_q <= 1'b0;
    end else begin
      cause_q   <= cause_d;
      tsd_q     <= tsd_d;
      hard_q    <= hard_in;
      det_clr_q <= !hard_in && fault_now && !fault_d;
    end
  end

  assign fault_mode_o = fault_now;
  assign sw_en_o      = !hard_q && !fault_now;
  assign det_clr_o    = det_clr_q;

  AST_TSD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_i && !hard_in |=> fault_mode_o && !sw_en_o); // R4
  AST_HARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hard_in |=> !sw_en_o && !fault_mode_o); // R11
  AST_SOVP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[CI_SOVP] && !hard_in |=> cause_q[CI_SOVP]); // R10
  AST_OTP_AFTER_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[CI_OTP]) |-> $past(ss_done_i)); // R3
  AST_OVLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[CI_OVLD]) |-> $past(sw_en_o)); // R6
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_clr_o |=> !det_clr_o); // R12
  AST_CLR_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    det_clr_o |-> sw_en_o); // R12
endmodule

// File: tb/tb_prot_fault_mgr.sv
`timescale 1ns/1ps
module tb_prot_fault_mgr;
  localparam int TD    = 4;
  localparam int N_OTP = 10;
  localparam int N_OVP = 6;
  localparam int N_SOV = 5;
  localparam int N_AR  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tsd_i = 0, otp_i = 0, otp_rec_i = 0, ovp_i = 0, sovp_i = 0;
  logic ovld_i = 0, scp_i = 0, ss_done_i = 0, otp_latch_i = 0, ovp_latch_i = 0;
  logic vcc_uv_i = 0, uvlo_rst_i = 0;
  logic sw_en_o, fault_mode_o, det_clr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prot_fault_mgr #(.TICK_DIV(TD), .OTP_TICKS(N_OTP), .OVP_TICKS(N_OVP),
                   .SOVP_TICKS(N_SOV), .AR_TICKS(N_AR)) dut (
    .clk(clk), .rst_n(rst_n), .tsd_i(tsd_i), .otp_i(otp_i), .otp_rec_i(otp_rec_i),
    .ovp_i(ovp_i), .sovp_i(sovp_i), .ovld_i(ovld_i), .scp_i(scp_i),
    .ss_done_i(ss_done_i), .otp_latch_i(otp_latch_i), .ovp_latch_i(ovp_latch_i),
    .vcc_uv_i(vcc_uv_i), .uvlo_rst_i(uvlo_rst_i),
    .sw_en_o(sw_en_o), .fault_mode_o(fault_mode_o), .det_clr_o(det_clr_o)
  );

  // expected windows derived from the requirements
  function automatic int filt_safe(int n); return (n - 1) * TD - 1; endfunction
  function automatic int filt_sure(int n); return n * TD + 2; endfunction
  function automatic int ar_min(); return (N_AR - 1) * TD; endfunction
  function automatic int ar_max(); return N_AR * TD + 3; endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_exit(int limit, output int cyc);
    cyc = 0;
    while (!sw_en_o && cyc < limit) begin
      step(1);
      cyc++;
    end
  endtask

  task automatic hard_reset(bit use_uv);
    if (use_uv) vcc_uv_i = 1; else uvlo_rst_i = 1;
    step(2);
    chk(!sw_en_o && !fault_mode_o, "R11 quiet during reset", {sw_en_o, fault_mode_o}, 0);
    vcc_uv_i = 0; uvlo_rst_i = 0;
    otp_i = 0; ovp_i = 0; sovp_i = 0; otp_rec_i = 0; otp_latch_i = 0; ovp_latch_i = 0;
    step(1);
    chk(sw_en_o && !fault_mode_o && !det_clr_o, "R11 resume after reset",
        {sw_en_o, fault_mode_o, det_clr_o}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'd2024));
    step(2);
    chk(sw_en_o && !fault_mode_o && !det_clr_o, "R1 in reset", {sw_en_o, fault_mode_o, det_clr_o}, 3'b100);
    rst_n = 1;
    step(3);
    chk(sw_en_o && !fault_mode_o && !det_clr_o, "R1 after reset", {sw_en_o, fault_mode_o, det_clr_o}, 3'b100);

    // R4 / R5 / R12: die shutdown follows its input
    tsd_i = 1; step(1);
    chk(fault_mode_o && !sw_en_o, "R4 R5 tsd entry", {fault_mode_o, sw_en_o}, 2'b10);
    tsd_i = 0; step(1);
    chk(sw_en_o && det_clr_o, "R4 R12 tsd exit with clear", {sw_en_o, det_clr_o}, 2'b11);
    step(1);
    chk(!det_clr_o, "R12 clear is one cycle", det_clr_o, 0);

    // R2: random short glitches on external over-voltage never trip
    for (int i = 0; i < 20; i++) begin
      ovp_i = 1; step(1 + ($urandom % filt_safe(N_OVP)));
      ovp_i = 0; step(1 + ($urandom % 3));
    end
    chk(!fault_mode_o, "R2 glitches filtered", fault_mode_o, 0);
    ovp_i = 1; step(filt_sure(N_OVP));
    chk(fault_mode_o && !sw_en_o, "R2 R5 ovp held trips", {fault_mode_o, sw_en_o}, 2'b10);
    // R8: held input keeps the fault across several periods
    step(2 * N_AR * TD);
    chk(fault_mode_o, "R8 held ovp stays in fault", fault_mode_o, 1);
    ovp_i = 0;
    wait_exit(3 * N_AR * TD, cyc);
    chk(cyc <= ar_max() && sw_en_o, "R8 exit after release", cyc, ar_max());
    chk(det_clr_o, "R12 clear on ovp exit", det_clr_o, 1);
    step(2);

    // R6: overload pulse, recovery period
    ovld_i = 1; step(1); ovld_i = 0;
    chk(fault_mode_o, "R6 overload entry", fault_mode_o, 1);
    wait_exit(3 * N_AR * TD, cyc);
    chk(cyc >= ar_min() && cyc <= ar_max(), "R6 overload recovery time", cyc, ar_min());
    step(2);
    scp_i = 1; step(1); scp_i = 0;
    chk(fault_mode_o, "R6 short-circuit entry", fault_mode_o, 1);
    wait_exit(3 * N_AR * TD, cyc);
    chk(cyc >= ar_min() && cyc <= ar_max(), "R6 short-circuit recovery time", cyc, ar_min());
    step(2);
    // R6: flag ignored while switching is off
    tsd_i = 1; step(1);
    scp_i = 1; step(1); scp_i = 0;
    tsd_i = 0; step(2);
    chk(sw_en_o && !fault_mode_o, "R6 flag ignored while disabled", {sw_en_o, fault_mode_o}, 2'b10);

    // R3: over-temperature masked before soft-start ends
    ss_done_i = 0; otp_i = 1; step(2 * filt_sure(N_OTP));
    chk(!fault_mode_o, "R3 otp masked", fault_mode_o, 0);
    ss_done_i = 1; otp_i = 0; step(1);
    // R2: a one-cycle drop restarts the count
    otp_i = 1; step(filt_safe(N_OTP)); otp_i = 0; step(1);
    otp_i = 1; step(filt_safe(N_OTP)); otp_i = 0; step(1);
    chk(!fault_mode_o, "R2 drop restarts filter", fault_mode_o, 0);
    otp_i = 1; step(filt_sure(N_OTP));
    chk(fault_mode_o, "R2 otp trips", fault_mode_o, 1);
    // R7: needs recovery flag as well as expiry
    otp_i = 0; otp_rec_i = 0; step(ar_max() + 20);
    chk(fault_mode_o, "R7 waits for recovery flag", fault_mode_o, 1);
    otp_rec_i = 1; step(2);
    chk(sw_en_o, "R7 exits once flag set", sw_en_o, 1);
    hard_reset(0);

    // R9: latch options
    otp_latch_i = 1; otp_i = 1; step(filt_sure(N_OTP));
    otp_i = 0; otp_rec_i = 1; step(3 * N_AR * TD);
    chk(fault_mode_o, "R9 otp latched", fault_mode_o, 1);
    hard_reset(1);
    ovp_latch_i = 1; ovp_i = 1; step(filt_sure(N_OVP));
    ovp_i = 0; step(3 * N_AR * TD);
    chk(fault_mode_o, "R9 ovp latched", fault_mode_o, 1);
    hard_reset(0);

    // R10: supply over-voltage always latches
    sovp_i = 1; step(filt_sure(N_SOV));
    chk(fault_mode_o, "R10 supply ovp trips", fault_mode_o, 1);
    sovp_i = 0; step(3 * N_AR * TD);
    chk(fault_mode_o, "R10 supply ovp latched", fault_mode_o, 1);
    hard_reset(1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule